// File: doc/BRIEF.md
# Asynchronous Host-Bus Read Slave

This block serves the read side of an SRAM-style host bus that drives a peripheral's register file without a shared clock. The host lowers an active-low chip-select and an active-low read-enable, in either order, while presenting a halfword address. The block brings both strobes into its own clock domain through synchronizer chains. It opens a read cycle once both strobes are low and closes it as soon as either one rises. While the cycle is open it drives the data lanes and raises the matching output-enables.

When a cycle opens, the block sends a single read pulse and the latched address to the register file, so that a register with a read side effect advances exactly once per cycle. In the same clock it freezes a copy of every live counter. A counter word is then returned from that frozen copy, so a host that reads a counter in two halfword parts, or reads several counters in turn, sees values that belong together. A mode pin picks the bus width. In the wide mode the whole word is returned. In the narrow mode the address LSB selects one halfword, and the upper lanes stay undriven.

If a new cycle opens before the strobes have been idle for the minimum gap, a sticky error flag is raised. The block still serves that cycle normally.

Top module: `pio_read_slave`

## Requirements
- R1: After reset, `rd_pulse`, `oe_lo`, `oe_hi` and `gap_err` are 0 and `d_out` is 0.
- R2: A cycle opens only when both `cs_n` and `rd_n` are low, whichever falls first. While only one of them is low, `oe_lo` and `rd_pulse` stay 0.
- R3: `rd_pulse` is high for exactly one clock, during the cycle after the third rising edge that follows the later strobe fall. In that cycle `rd_addr` equals the `addr` presented.
- R4: `oe_lo` rises and `d_out` carries the read data after the fourth rising edge that follows the later strobe fall. Both hold steady until the cycle closes.
- R5: A cycle closes when either strobe rises. `oe_lo`, `oe_hi` and `d_out` return to 0 after the third rising edge that follows that rise.
- R6: An address whose word index `addr[6:1]` is below NUM_CNT (2 by default) returns counter number `addr[6:1]`, zero-extended to 32 bits, as it stood at the edge that raised `rd_pulse`. Changes to `cnt_live` after that edge do not appear in the returned data.
- R7: Any other address returns `rf_rdata` as sampled one clock after `rd_pulse`, while `rd_addr` still holds the cycle's address.
- R8: With `bus_is16`=0, `oe_hi` follows `oe_lo` and `d_out` carries the full 32-bit word. `addr[0]` does not select a half.
- R9: With `bus_is16`=1, `oe_hi` stays 0 and `d_out[31:16]` is 0. `d_out[15:0]` is bits 31:16 of the word when `addr[0]`=1 and bits 15:0 when `addr[0]`=0.
- R10: If both strobes read low again after fewer than MIN_GAP_CLKS (2) synchronized clocks of idle, `gap_err` rises and stays at 1 until reset. The new cycle still produces `rd_pulse` and data.
- R11: Cycles separated by at least MIN_GAP_CLKS idle clocks leave `gap_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_is16 | input | 1 | 1 selects the 16-bit bus mode; static during operation |
| cs_n | input | 1 | Asynchronous active-low chip-select |
| rd_n | input | 1 | Asynchronous active-low read-enable |
| addr | input | 7 | Halfword address, stable while the strobes are low |
| cnt_live | input | 48 | Live counters, NUM_CNT fields of CNT_W bits, counter 0 in the LSBs |
| rf_rdata | input | 32 | Register-file word for `rd_addr` |
| rd_pulse | output | 1 | One-clock read strobe to the register file per cycle |
| rd_addr | output | 7 | Address latched at cycle open |
| d_out | output | 32 | Read data toward the pad drivers |
| oe_lo | output | 1 | Output-enable for lanes 15:0 |
| oe_hi | output | 1 | Output-enable for lanes 31:16 |
| gap_err | output | 1 | Sticky flag for a too-short gap between cycles |

## Verification
The bench changes strobes on falling clock edges and counts rising edges from that point. `rd_pulse` is due after the third edge, since two synchronizer flops and the pulse register lie on the path. Data and `oe_lo` are due after the fourth edge, and the enables drop after the third edge following a strobe rise. Every check samples 3 ns after the edge it is counted against. The bench also samples the clocks just before each due edge, which shows that nothing arrives early. The counter snapshot is tested by changing `cnt_live` in the window between the pulse and the data load. The gap error is provoked by releasing a strobe for a single clock.

// File: rtl/pio_rd_pkg.sv
package pio_rd_pkg;

   typedef enum logic {
      BUS_W32 = 1'b0,
      BUS_W16 = 1'b1
   } bus_mode_e;

   // saturating increment used by the idle-gap counter
   function automatic logic [7:0] sat_inc8(input logic [7:0] v, input logic [7:0] lim);
      return (v >= lim) ? lim : v + 8'd1;
   endfunction

endpackage

// File: rtl/pio_strobe_sync.sv
module pio_strobe_sync #(
   parameter int           WIDTH   = 2,
   parameter int           STAGES  = 2,
   parameter logic         RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   initial begin
      if (STAGES < 2) $fatal(1, "pio_strobe_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $fatal(1, "pio_strobe_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= {WIDTH{RST_VAL}};
               else        chain_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= {WIDTH{RST_VAL}};
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pio_cycle_ctl.sv
module pio_cycle_ctl
   import pio_rd_pkg::*;
#(
   parameter int MIN_GAP_CLKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s_i,
   input  logic rd_s_i,
   output logic start_o,
   output logic end_o,
   output logic active_o,
   output logic gap_err_o
);

   localparam int GAP_W = (MIN_GAP_CLKS < 2) ? 1 : $clog2(MIN_GAP_CLKS + 1);
   localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MIN_GAP_CLKS);

   initial begin
      if (MIN_GAP_CLKS < 1)   $fatal(1, "pio_cycle_ctl: MIN_GAP_CLKS must be at least 1");
      if (MIN_GAP_CLKS > 255) $fatal(1, "pio_cycle_ctl: MIN_GAP_CLKS above 255");
   end

   logic             act_q;
   logic [GAP_W-1:0] gap_q;
   logic             err_q;
   logic             both_low;

   assign both_low = ~cs_s_i & ~rd_s_i;
   assign active_o = both_low;
   assign start_o  = both_low & ~act_q;
   assign end_o    = ~both_low & act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= both_low;
   end

   // idle clocks since the last cycle closed; starts saturated so the
   // first cycle after reset is legal
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gap_q <= GAP_LIM;
      else if (both_low) gap_q <= '0;
      else               gap_q <= GAP_W'(sat_inc8(8'(gap_q), 8'(MIN_GAP_CLKS)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          err_q <= 1'b0;
      else if (start_o && gap_q < GAP_LIM) err_q <= 1'b1;
   end

   assign gap_err_o = err_q;

   // R10: the error flag never clears once set
   p_gap_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      gap_err_o |=> gap_err_o);

   // R2: the open and close pulses never appear back to back
   p_start_then_no_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !end_o);

endmodule

// File: rtl/pio_rd_datapath.sv
module pio_rd_datapath
   import pio_rd_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 24,
   parameter int NUM_CNT = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     capture_i,
   input  logic                     load_i,
   input  bus_mode_e                mode_i,
   input  logic [ADDR_W-1:0]        word_addr_i,
   input  logic [NUM_CNT*CNT_W-1:0] cnt_live_i,
   input  logic [DATA_W-1:0]        rf_rdata_i,
   output logic [DATA_W-1:0]        data_o
);

   localparam int HALF_W = DATA_W / 2;
   localparam int WIDX_W = ADDR_W - 1;

   initial begin
      if (DATA_W % 2 != 0)             $fatal(1, "pio_rd_datapath: DATA_W must be even");
      if (CNT_W > DATA_W)              $fatal(1, "pio_rd_datapath: CNT_W exceeds DATA_W");
      if (NUM_CNT < 1)                 $fatal(1, "pio_rd_datapath: NUM_CNT must be positive");
      if (NUM_CNT > (1 << WIDX_W))     $fatal(1, "pio_rd_datapath: NUM_CNT exceeds word space");
   end

   logic [CNT_W-1:0]  snap_q [NUM_CNT];
   logic [WIDX_W-1:0] word_idx;
   logic [DATA_W-1:0] full_word;
   logic [HALF_W-1:0] lane;
   logic [DATA_W-1:0] bus_word;
   logic [DATA_W-1:0] data_q;

   assign word_idx = word_addr_i[ADDR_W-1:1];

   genvar k;
   generate
      for (k = 0; k < NUM_CNT; k++) begin : g_snap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         snap_q[k] <= '0;
            else if (capture_i) snap_q[k] <= cnt_live_i[k*CNT_W +: CNT_W];
         end

         // R6: the frozen copy only moves at cycle open
         p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !capture_i |=> $stable(snap_q[k]));
      end
   endgenerate

   always_comb begin
      full_word = rf_rdata_i;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (word_idx == WIDX_W'(i)) full_word = DATA_W'(snap_q[i]);
      end
   end

   assign lane     = word_addr_i[0] ? full_word[DATA_W-1:HALF_W] : full_word[HALF_W-1:0];
   assign bus_word = (mode_i == BUS_W16) ? {{HALF_W{1'b0}}, lane} : full_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      data_q <= '0;
      else if (load_i) data_q <= bus_word;
   end

   assign data_o = data_q;

endmodule

// File: rtl/pio_read_slave.sv
module pio_read_slave
   import pio_rd_pkg::*;
#(
   parameter int ADDR_W       = 7,
   parameter int DATA_W       = 32,
   parameter int CNT_W        = 24,
   parameter int NUM_CNT      = 2,
   parameter int SYNC_STAGES  = 2,
   parameter int MIN_GAP_CLKS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_is16,
   input  logic                     cs_n,
   input  logic                     rd_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [NUM_CNT*CNT_W-1:0] cnt_live,
   input  logic [DATA_W-1:0]        rf_rdata,
   output logic                     rd_pulse,
   output logic [ADDR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]        d_out,
   output logic                     oe_lo,
   output logic                     oe_hi,
   output logic                     gap_err
);

   localparam int HALF_W = DATA_W / 2;

   initial begin
      if (ADDR_W < 2) $fatal(1, "pio_read_slave: ADDR_W must be at least 2");
   end

   logic [1:0]        strobes_s;
   logic              cyc_start;
   logic              cyc_end;
   logic              cyc_active;
   logic              pulse_q;
   logic [ADDR_W-1:0] addr_q;
   bus_mode_e         mode_q;
   logic              oe_q;
   logic [DATA_W-1:0] data_w;

   pio_strobe_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_n, rd_n}),
      .q_o   (strobes_s)
   );

   pio_cycle_ctl #(
      .MIN_GAP_CLKS (MIN_GAP_CLKS)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s_i    (strobes_s[1]),
      .rd_s_i    (strobes_s[0]),
      .start_o   (cyc_start),
      .end_o     (cyc_end),
      .active_o  (cyc_active),
      .gap_err_o (gap_err)
   );

   // cycle-open stage: strobe, address and mode captured together
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         addr_q  <= '0;
         mode_q  <= BUS_W32;
      end else begin
         pulse_q <= cyc_start;
         if (cyc_start) begin
            addr_q <= addr;
            mode_q <= bus_is16 ? BUS_W16 : BUS_W32;
         end
      end
   end

   pio_rd_datapath #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .CNT_W   (CNT_W),
      .NUM_CNT (NUM_CNT)
   ) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture_i   (cyc_start),
      .load_i      (pulse_q),
      .mode_i      (mode_q),
      .word_addr_i (addr_q),
      .cnt_live_i  (cnt_live),
      .rf_rdata_i  (rf_rdata),
      .data_o      (data_w)
   );

   // drive stage: enable from data load until either strobe rises
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= cyc_active & (oe_q | pulse_q);
   end

   assign rd_pulse = pulse_q;
   assign rd_addr  = addr_q;
   assign oe_lo    = oe_q;
   assign oe_hi    = oe_q & (mode_q == BUS_W32);
   assign d_out[HALF_W-1:0]      = oe_q ? data_w[HALF_W-1:0] : '0;
   assign d_out[DATA_W-1:HALF_W] = oe_hi ? data_w[DATA_W-1:HALF_W] : '0;

   // R3: one register-file strobe per cycle
   p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pulse |=> !rd_pulse);

   // R4: the drivers only turn on right after the read strobe
   p_oe_after_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_lo) |-> $past(rd_pulse));

   // R5: a close pulse turns the drivers off on the next edge
   p_close_drops_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_end |=> !oe_lo);

   // R9: narrow mode never enables the upper lanes (mode pin is static)
   p_upper_off_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      oe_hi |-> !bus_is16);

   // R8: upper lanes are never enabled alone
   p_hi_needs_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_hi |-> oe_lo);

endmodule

// File: tb/pio_read_slave_test.sv
`timescale 1ns/1ps
module pio_read_slave_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_is16 = 1'b0;
   logic        cs_n = 1'b1;
   logic        rd_n = 1'b1;
   logic [6:0]  addr = '0;
   logic [23:0] cnt0 = '0;
   logic [23:0] cnt1 = '0;
   logic [31:0] rf_rdata;
   logic        rd_pulse;
   logic [6:0]  rd_addr;
   logic [31:0] d_out;
   logic        oe_lo;
   logic        oe_hi;
   logic        gap_err;

   int n_checks = 0;
   int n_errors = 0;

   always #5 clk = ~clk;

   // register-file model: a word built from the latched address
   assign rf_rdata = {16'hC0DE, 9'd0, rd_addr};

   pio_read_slave uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_is16 (bus_is16),
      .cs_n     (cs_n),
      .rd_n     (rd_n),
      .addr     (addr),
      .cnt_live ({cnt1, cnt0}),
      .rf_rdata (rf_rdata),
      .rd_pulse (rd_pulse),
      .rd_addr  (rd_addr),
      .d_out    (d_out),
      .oe_lo    (oe_lo),
      .oe_hi    (oe_hi),
      .gap_err  (gap_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #3;
   endtask

   function automatic logic [31:0] rf_word(input logic [6:0] a);
      return {16'hC0DE, 9'd0, a};
   endfunction

   // one full read; cs_first picks the fall order, close_cs picks which
   // strobe rises first; poke changes counter 0 between pulse and load
   task automatic do_read(input string tag, input logic [6:0] a, input bit cs_first,
                          input bit close_cs, input logic [31:0] exp,
                          input bit exp_hi, input bit poke);
      @(negedge clk);
      addr = a;
      if (cs_first) cs_n = 1'b0; else rd_n = 1'b0;
      edges(4);
      chk({tag, " R2 one strobe no oe"}, {31'd0, oe_lo}, 32'd0);
      chk({tag, " R2 one strobe no pulse"}, {31'd0, rd_pulse}, 32'd0);
      @(negedge clk);
      if (cs_first) rd_n = 1'b0; else cs_n = 1'b0;
      edges(2);
      chk({tag, " R3 not early"}, {31'd0, rd_pulse}, 32'd0);
      edges(1);
      chk({tag, " R3 pulse"}, {31'd0, rd_pulse}, 32'd1);
      chk({tag, " R3 addr"}, {25'd0, rd_addr}, {25'd0, a});
      chk({tag, " R4 oe not early"}, {31'd0, oe_lo}, 32'd0);
      if (poke) cnt0 = 24'hFFFFFF;
      edges(1);
      chk({tag, " R3 pulse single"}, {31'd0, rd_pulse}, 32'd0);
      chk({tag, " R4 oe_lo"}, {31'd0, oe_lo}, 32'd1);
      chk({tag, " R8/R9 oe_hi"}, {31'd0, oe_hi}, {31'd0, exp_hi});
      chk({tag, " R4 data"}, d_out, exp);
      edges(3);
      chk({tag, " R4 data held"}, d_out, exp);
      @(negedge clk);
      if (close_cs) cs_n = 1'b1; else rd_n = 1'b1;
      edges(2);
      chk({tag, " R5 still on"}, {31'd0, oe_lo}, 32'd1);
      edges(1);
      chk({tag, " R5 oe off"}, {30'd0, oe_hi, oe_lo}, 32'd0);
      chk({tag, " R5 data off"}, d_out, 32'd0);
      @(negedge clk);
      cs_n = 1'b1;
      rd_n = 1'b1;
      edges(4);
   endtask

   task automatic t_reset;
      chk("R1 rd_pulse", {31'd0, rd_pulse}, 32'd0);
      chk("R1 oe", {30'd0, oe_hi, oe_lo}, 32'd0);
      chk("R1 gap_err", {31'd0, gap_err}, 32'd0);
      chk("R1 d_out", d_out, 32'd0);
   endtask

   task automatic t_wide_regfile;
      bus_is16 = 1'b0;
      do_read("wide cs-first", 7'h10, 1'b1, 1'b1, rf_word(7'h10), 1'b1, 1'b0); // R7 R8
      do_read("wide rd-first", 7'h25, 1'b0, 1'b0, rf_word(7'h25), 1'b1, 1'b0); // R7 R8 addr[0] ignored
   endtask

   task automatic t_counter_snapshot;
      bus_is16 = 1'b0;
      cnt0 = 24'h123456;
      cnt1 = 24'hABCDEF;
      do_read("R6 snap c0", 7'h00, 1'b1, 1'b0, 32'h00123456, 1'b1, 1'b1);
      do_read("R6 c1", 7'h03, 1'b0, 1'b1, 32'h00ABCDEF, 1'b1, 1'b0);
   endtask

   task automatic t_narrow;
      @(negedge clk);
      bus_is16 = 1'b1;
      do_read("R9 c1 upper", 7'h03, 1'b1, 1'b1, 32'h000000AB, 1'b0, 1'b0);
      do_read("R9 rf lower", 7'h10, 1'b0, 1'b0, 32'h00000010, 1'b0, 1'b0);
      do_read("R9 rf upper", 7'h11, 1'b1, 1'b0, 32'h0000C0DE, 1'b0, 1'b0);
      @(negedge clk);
      bus_is16 = 1'b0;
   endtask

   task automatic t_gap_ok;
      chk("R11 no error after spaced cycles", {31'd0, gap_err}, 32'd0);
   endtask

   task automatic t_gap_short;
      @(negedge clk);
      addr = 7'h12;
      cs_n = 1'b0;
      rd_n = 1'b0;
      edges(6);
      chk("R10 first cycle on", {31'd0, oe_lo}, 32'd1);
      @(negedge clk);
      rd_n = 1'b1;
      @(negedge clk);
      addr = 7'h14;
      rd_n = 1'b0;
      // rd_n released for one clock; next pulse three edges after it returns low
      edges(3);
      chk("R10 second pulse", {31'd0, rd_pulse}, 32'd1);
      chk("R10 second addr", {25'd0, rd_addr}, 32'h14);
      edges(1);
      chk("R10 gap_err set", {31'd0, gap_err}, 32'd1);
      chk("R10 second data", d_out, rf_word(7'h14));
      @(negedge clk);
      cs_n = 1'b1;
      rd_n = 1'b1;
      edges(8);
      chk("R10 gap_err sticky", {31'd0, gap_err}, 32'd1);
   endtask

   initial begin : watchdog
      #1_000_000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #3;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      edges(2);
      t_reset();
      t_wide_regfile();
      t_counter_snapshot();
      t_narrow();
      t_gap_ok();
      t_gap_short();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule